// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register file of a legacy printer-style parallel port. It uses eight-bit registers and single-cycle accesses. A host reads and writes four registers, selected by the three lowest address bits: a byte that goes out, a byte that comes in, a status register and a control register. The block has no printer pins and no attached device. It imitates the printer's side of the handshake instead. A strobe edge written to the control register hands the outgoing byte to a valid/data sink. Status reads walk the busy and acknowledge flags through a fixed sequence. An interrupt request stays pending until the host reads status.

The incoming byte is not driven by a register write. A separate load port fills it, and the host sees it through the data offset when the control direction bit asks for input. Each access takes one cycle: `rd_en` or `wr_en` is held high for one clock. Read data is combinational from the current register state. All side effects take effect at the clock edge that ends the access.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, reads give 0x00 at the data offset, 0xD8 at the status offset and 0x00 at the control offset. `irq` and `byte_valid` are low.
- R2: Only address bits [2:0] select a register: 0 is data, 1 is status, 2 is control. Higher address bits are ignored. Reads of offsets 3 to 7 return 0xFF, and writes to them change nothing.
- R3: A data read returns the input latch when control bit 5 (direction) is 1. Otherwise it returns the last byte written to the data offset.
- R4: A control write with bit 2 (init) at 0 sets status to 0xD8. Status bit 7 is not-busy, bit 6 is acknowledge, bit 4 is online and bit 3 is not-error.
- R5: A control write with init=1, bit 3 (select)=1 and bit 0 (strobe)=1 clears status bit 7. If the stored strobe was 0 before that write, `byte_valid` is high for exactly the following cycle and `byte_out` carries the output data latch.
- R6: A control write with init=1, select=1 and strobe=0 sets the pending interrupt when the stored control had bit 4 (interrupt enable) set before the write. `irq` follows the pending flag from the next cycle.
- R7: The control register always takes the full written byte, and a control read returns it. The side effects of R4 to R6 are judged against the control value held before the write.
- R8: A status read returns the current status and clears the pending interrupt.
- R9: After a status read that found bit 7 at 0 while the stored strobe is 0, status changes as follows. If bit 6 was 1, it is cleared. If bit 6 was 0, bits 6 and 7 are both set.
- R10: Writes to the status offset have no effect.
- R11: With `in_load` high, `in_byte` is captured into the input latch at the clock edge.
- R12: When `rd_en` and `wr_en` are both high, only the write's effects are applied. The read returns data but has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| addr | input | ADDR_W | register address, bits [2:0] decoded |
| rd_en | input | 1 | read strobe, one cycle per access |
| wr_en | input | 1 | write strobe, one cycle per access |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, combinational |
| in_load | input | 1 | load input latch |
| in_byte | input | 8 | byte for the input latch |
| byte_valid | output | 1 | one-cycle pulse when a byte is emitted |
| byte_out | output | 8 | emitted byte |
| irq | output | 1 | interrupt request level |

## Verification
The bench builds the block with ADDR_W=8, so every one of the 256 addresses can be read. This shows that only the low three bits decode and that the upper offsets return the fill value. All 256 control values are written after each of four earlier control values. The four earlier values cover every combination of stored strobe and interrupt enable, so the emit rule, the interrupt rule and the status load are checked against arithmetic expectations in every case. Directed sequences then follow the acknowledge/busy stepping over successive status reads, and cover the input latch, status writes and simultaneous read/write.

// File: rtl/prn_pkg.sv
package prn_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] OFS_DATA = 3'd0;
    localparam logic [SEL_W-1:0] OFS_STAT = 3'd1;
    localparam logic [SEL_W-1:0] OFS_CTRL = 3'd2;

    localparam int ST_NBUSY = 7;
    localparam int ST_ACK   = 6;

    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hD8;
    localparam logic [BYTE_W-1:0] RD_FILL   = 8'hFF;

    typedef struct packed {
        logic [BYTE_W-1:0] dout;
        logic [BYTE_W-1:0] din;
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] ctrl;
        logic              pend;
        logic              emit;
        logic [BYTE_W-1:0] emit_byte;
    } prn_regs_t;

endpackage

// File: rtl/prn_ctrl_fx.sv
module prn_ctrl_fx
    import prn_pkg::*;
(
    input  logic              old_stb,
    input  logic              old_ien,
    input  logic              new_init,
    input  logic              new_sel,
    input  logic              new_stb,
    input  logic [BYTE_W-1:0] cur_stat,
    output logic [BYTE_W-1:0] stat_nx,
    output logic              emit,
    output logic              raise
);
    always_comb begin
        stat_nx = cur_stat;
        emit    = 1'b0;
        raise   = 1'b0;
        if (!new_init) begin
            stat_nx = STAT_IDLE;
        end else if (new_sel) begin
            if (new_stb) begin
                stat_nx[ST_NBUSY] = 1'b0;
                emit              = ~old_stb;
            end else begin
                raise = old_ien;
            end
        end
    end
endmodule

// File: rtl/prn_stat_step.sv
module prn_stat_step
    import prn_pkg::*;
(
    input  logic [BYTE_W-1:0] stat,
    input  logic              ctrl_stb,
    output logic [BYTE_W-1:0] stat_nx
);
    always_comb begin
        stat_nx = stat;
        if (!stat[ST_NBUSY] && !ctrl_stb) begin
            if (stat[ST_ACK]) begin
                stat_nx[ST_ACK] = 1'b0;
            end else begin
                stat_nx[ST_ACK]   = 1'b1;
                stat_nx[ST_NBUSY] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prn_rd_mux.sv
module prn_rd_mux
    import prn_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] dout,
    input  logic [BYTE_W-1:0] din,
    input  logic [BYTE_W-1:0] stat,
    input  logic [BYTE_W-1:0] ctrl,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        unique case (sel)
            OFS_DATA: rdata = ctrl[CT_DIR] ? din : dout;
            OFS_STAT: rdata = stat;
            OFS_CTRL: rdata = ctrl;
            default:  rdata = RD_FILL;
        endcase
    end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
    import prn_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              in_load,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_out,
    output logic              irq
);
    localparam int HI_W = (ADDR_W > SEL_W) ? ADDR_W - SEL_W : 1;

    prn_regs_t         r_q, r_d;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] fx_stat, step_stat;
    logic              fx_emit, fx_raise;

    assign sel = addr[SEL_W-1:0];

    generate
        if (ADDR_W > SEL_W) begin : g_hi
            logic [HI_W-1:0] unused_addr_hi;
            assign unused_addr_hi = addr[ADDR_W-1:SEL_W];
        end
    endgenerate

    prn_ctrl_fx u_fx (
        .old_stb  (r_q.ctrl[CT_STB]),
        .old_ien  (r_q.ctrl[CT_IEN]),
        .new_init (wdata[CT_INIT]),
        .new_sel  (wdata[CT_SEL]),
        .new_stb  (wdata[CT_STB]),
        .cur_stat (r_q.stat),
        .stat_nx  (fx_stat),
        .emit     (fx_emit),
        .raise    (fx_raise)
    );

    prn_stat_step u_step (
        .stat     (r_q.stat),
        .ctrl_stb (r_q.ctrl[CT_STB]),
        .stat_nx  (step_stat)
    );

    prn_rd_mux u_mux (
        .sel   (sel),
        .dout  (r_q.dout),
        .din   (r_q.din),
        .stat  (r_q.stat),
        .ctrl  (r_q.ctrl),
        .rdata (rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.emit = 1'b0;
        if (in_load) r_d.din = in_byte;
        if (wr_en) begin
            unique case (sel)
                OFS_DATA: r_d.dout = wdata;
                OFS_CTRL: begin
                    r_d.stat      = fx_stat;
                    r_d.emit      = fx_emit;
                    r_d.emit_byte = r_q.dout;
                    if (fx_raise) r_d.pend = 1'b1;
                    r_d.ctrl      = wdata;
                end
                default: ;
            endcase
        end else if (rd_en && sel == OFS_STAT) begin
            r_d.pend = 1'b0;
            r_d.stat = step_stat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.stat <= STAT_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_valid = r_q.emit;
    assign byte_out   = r_q.emit_byte;
    assign irq        = r_q.pend;

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && sel == OFS_STAT) |=> !irq);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_init_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == OFS_CTRL && !wdata[CT_INIT]) |=> (r_q.stat == STAT_IDLE));

    assert_ctrl_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == OFS_CTRL) |=> (r_q.ctrl == $past(wdata)));

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en && sel == OFS_CTRL && wdata[CT_INIT]
                             && wdata[CT_SEL] && !wdata[CT_STB]));

    assert_stat_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == OFS_STAT) |=> $stable(r_q.stat));
endmodule

// File: tb/prn_port_regs_test.sv
module prn_port_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0, in_load = 1'b0;
    logic [7:0] wdata = '0, in_byte = '0;
    logic [7:0] rdata, byte_out;
    logic       byte_valid, irq;
    int         checks = 0, fails = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    prn_port_regs #(.ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .in_load(in_load), .in_byte(in_byte),
        .byte_valid(byte_valid), .byte_out(byte_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1; #2 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] prevs [4];
        prevs[0] = 8'h00; prevs[1] = 8'h01; prevs[2] = 8'h10; prevs[3] = 8'h11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 byte_valid", {7'd0, byte_valid}, 8'h00);
        do_rd(8'h02, rv); check("R1 ctrl", rv, 8'h00);
        do_rd(8'h00, rv); check("R1 data", rv, 8'h00);

        // R2 sweep of all addresses
        for (int a = 0; a < 256; a++) begin
            logic [7:0] e;
            case (a % 8)
                0: e = 8'h00;
                1: e = 8'hD8;
                2: e = 8'h00;
                default: e = 8'hFF;
            endcase
            do_rd(a[7:0], rv); check("R2 decode", rv, e);
        end

        // R2 upper offsets writes ignored, alias write to data
        do_wr(8'h05, 8'h77); do_wr(8'h0B, 8'h66);
        do_rd(8'h02, rv); check("R2 ctrl untouched", rv, 8'h00);
        do_rd(8'h01, rv); check("R2 stat untouched", rv, 8'hD8);
        do_wr(8'h48, 8'hA5);
        do_rd(8'h00, rv); check("R2 alias data", rv, 8'hA5);

        // R11 / R3 input latch and direction
        @(negedge clk); in_byte = 8'h3C; in_load = 1'b1;
        @(negedge clk); in_load = 1'b0; in_byte = 8'h00;
        do_rd(8'h00, rv); check("R3 dir0 output latch", rv, 8'hA5);
        do_wr(8'h02, 8'h20);
        do_rd(8'h00, rv); check("R11 R3 dir1 input latch", rv, 8'h3C);

        // R4 R5 R6 R7 sweep over all control values after four stored states
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] pv, nv, es;
                logic       ee, ei;
                pv = prevs[p]; nv = v[7:0];
                do_wr(8'h02, pv);
                do_rd(8'h01, rv);
                do_wr(8'h02, nv);
                ee = nv[2] & nv[3] & nv[0] & ~pv[0];
                ei = nv[2] & nv[3] & ~nv[0] & pv[4];
                es = (nv[2] & nv[3] & nv[0]) ? 8'h58 : 8'hD8;
                check("R5 byte_valid", {7'd0, byte_valid}, {7'd0, ee});
                if (ee) check("R5 byte_out", byte_out, 8'hA5);
                check("R6 irq", {7'd0, irq}, {7'd0, ei});
                if (ee) begin
                    @(negedge clk);
                    check("R5 pulse ends", {7'd0, byte_valid}, 8'h00);
                end
                do_rd(8'h02, rv); check("R7 ctrl readback", rv, nv);
                do_rd(8'h01, rv); check("R4 R5 status", rv, es);
                check("R8 irq cleared", {7'd0, irq}, 8'h00);
            end
        end

        // R9 acknowledge/busy stepping
        do_wr(8'h02, 8'h00);
        do_wr(8'h02, 8'h0D);
        do_wr(8'h02, 8'h0C);
        check("R6 no irq without enable", {7'd0, irq}, 8'h00);
        do_rd(8'h01, rv); check("R9 read1", rv, 8'h58);
        do_rd(8'h01, rv); check("R9 read2 ack cleared", rv, 8'h18);
        do_rd(8'h01, rv); check("R9 read3 ack busy set", rv, 8'hD8);
        do_rd(8'h01, rv); check("R9 read4 steady", rv, 8'hD8);

        // R6 / R8 interrupt via enable held in stored control
        do_wr(8'h02, 8'h1C);
        check("R6 old enable clear", {7'd0, irq}, 8'h00);
        do_wr(8'h02, 8'h1C);
        check("R6 irq raised", {7'd0, irq}, 8'h01);
        do_rd(8'h02, rv);
        check("R8 ctrl read keeps irq", {7'd0, irq}, 8'h01);
        do_rd(8'h01, rv);
        check("R8 status read clears irq", {7'd0, irq}, 8'h00);

        // R10 status write ignored
        do_wr(8'h02, 8'h0D);
        do_wr(8'h02, 8'h0C);
        do_wr(8'h01, 8'h00);
        do_wr(8'h01, 8'hFF);
        // R12 simultaneous read and write at status offset
        @(negedge clk); addr = 8'h01; wdata = 8'h00; rd_en = 1'b1; wr_en = 1'b1;
        #2 rv = rdata;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        check("R12 read data", rv, 8'h58);
        do_rd(8'h01, rv); check("R10 R12 status unchanged", rv, 8'h58);

        // R12 simultaneous at control offset: write applied
        @(negedge clk); addr = 8'h02; wdata = 8'h2A; rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        do_rd(8'h02, rv); check("R12 write applied", rv, 8'h2A);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule